// File: doc/BRIEF.md
# Tagged-Token Operand Matching Unit

This unit sits in front of the execute stage of a dynamic dataflow processing element. Tokens arrive one per cycle. Each token carries a 64-bit data value, a tag made of a thread number and a wave number, the instruction slot it is addressed to, and the input port it fills. The unit gathers these operands until an instruction instance is complete, then sends one fire packet downstream. The packet carries the tag, the slot and every operand value.

Operands are matched on slot, thread and wave together. This lets several dynamic instances of the same instruction wait side by side: different waves of a loop body, or different threads running the same code. Partially filled operand sets are kept in a small associative table. An instruction that takes a single operand skips the table and goes straight to the fire register. The fire output uses a valid/ready handshake. A table entry is released only when its packet is taken.

Top module: `opnd_match`

## Requirements
- R1: A fire packet for a slot, thread and wave is produced only once every port that slot requires has received a token carrying that same slot, thread and wave.
- R2: The number of operands each slot needs comes from the parameter `SLOT_ARITY`, which holds two bits per slot at bit positions [2s+1:2s] for slot s. The value 2 means ports A and B, 3 means A, B and C, and 1 or 0 means port A alone. The default gives slots 0 to 7 the counts 1,2,3,2,3,1,2,3.
- R3: Port numbers are encoded 0 = A, 1 = B, 2 = C. The fire packet returns each operand on `fire_a`, `fire_b` and `fire_c` whatever order the tokens arrived in. Ports the slot does not use read as zero.
- R4: Tokens for the same slot with a different thread or a different wave go into separate operand sets. Each set fires with its own values.
- R5: A one-operand token on port A is accepted only when the fire register is free or being emptied and no completed table entry is waiting. It appears as a fire packet on the cycle after it is accepted, with `fire_b` and `fire_c` at zero.
- R6: When a token completes a multi-operand set, `fire_valid` rises at the second clock edge after that token is accepted. This assumes the fire register is free.
- R7: A multi-operand token whose slot and tag match no entry allocates a free entry. When none is free, `tok_ready` stays low and the token is held back. Tokens that match an existing entry are still accepted.
- R8: A token for a port that is already filled in its matching entry is accepted and dropped, and sets the sticky `err_flag`. The same applies to a token for a port outside the slot's operand count (or port code 3). The flag stays set until reset.
- R9: While `fire_ready` is low, `fire_valid` and the whole packet hold steady. The table entry behind the packet stays occupied until the cycle the packet is accepted.
- R10: After reset, `fire_valid` and `err_flag` are low and the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | Token present |
| tok_ready | output | 1 | Token can be accepted this cycle |
| tok_thread | input | TW | Thread number of the tag |
| tok_wave | input | WW | Wave number of the tag |
| tok_slot | input | log2(SLOTS) | Instruction slot addressed |
| tok_port | input | 2 | Input port: 0 = A, 1 = B, 2 = C |
| tok_value | input | DW | Data value |
| fire_valid | output | 1 | Fire packet present |
| fire_ready | input | 1 | Downstream takes the fire packet |
| fire_thread | output | TW | Thread of the firing instance |
| fire_wave | output | WW | Wave of the firing instance |
| fire_slot | output | log2(SLOTS) | Slot of the firing instance |
| fire_a | output | DW | Operand A |
| fire_b | output | DW | Operand B, zero if unused |
| fire_c | output | DW | Operand C, zero if unused |
| err_flag | output | 1 | Sticky duplicate or invalid port error |

## Verification
Inputs change on the falling edge, so a token is taken at the next rising edge. A one-operand packet is sampled on the very next falling edge. A completing multi-operand token leaves `fire_valid` low at that falling edge and high one falling edge later, and the bench checks both. The error flag is read on the falling edge right after the offending token is taken. `tok_ready` is read 1 ns after the falling edge on which the token is driven. In the full-table case, the bench first confirms that `tok_ready` stays low while a finished packet is held back. It then checks that `tok_ready` rises on the first falling edge after the packet is accepted.

// File: rtl/opm_pkg.sv
package opm_pkg;
  typedef enum logic [1:0] {
    PORT_A = 2'd0,
    PORT_B = 2'd1,
    PORT_C = 2'd2,
    PORT_X = 2'd3
  } port_e;

  // required-port mask for a slot's operand count
  function automatic logic [2:0] need_mask(input logic [1:0] cnt);
    case (cnt)
      2'd2:    need_mask = 3'b011;
      2'd3:    need_mask = 3'b111;
      default: need_mask = 3'b001;
    endcase
  endfunction

  // one-hot form of a port code, empty for the unused code
  function automatic logic [2:0] port_onehot(input logic [1:0] p);
    port_onehot = (p == PORT_X) ? 3'b000 : (3'b001 << p);
  endfunction
endpackage

// File: rtl/opm_pick.sv
module opm_pick #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/opm_table.sv
module opm_table
  import opm_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int TW      = 4,
  parameter int WW      = 8,
  parameter int SW      = 3,
  parameter int DW      = 64,
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] in_thread,
  input  logic [WW-1:0] in_wave,
  input  logic [SW-1:0] in_slot,
  input  logic [1:0]    in_port,
  input  logic [DW-1:0] in_value,
  input  logic [2:0]    in_need,
  input  logic          wr_en,
  output logic          hit,
  output logic          full,
  output logic          dup,
  output logic          rdy_any,
  input  logic          iss_en,
  input  logic          rel_en,
  output logic [TW-1:0] out_thread,
  output logic [WW-1:0] out_wave,
  output logic [SW-1:0] out_slot,
  output logic [DW-1:0] out_a,
  output logic [DW-1:0] out_b,
  output logic [DW-1:0] out_c
);
  logic [ENTRIES-1:0] e_val, e_iss, match, done, freev;
  logic [TW-1:0] e_thr  [ENTRIES];
  logic [WW-1:0] e_wav  [ENTRIES];
  logic [SW-1:0] e_slt  [ENTRIES];
  logic [2:0]    e_pres [ENTRIES];
  logic [2:0]    e_need [ENTRIES];
  logic [DW-1:0] e_opa  [ENTRIES];
  logic [DW-1:0] e_opb  [ENTRIES];
  logic [DW-1:0] e_opc  [ENTRIES];

  logic [IW-1:0] hit_idx, free_idx, rdy_idx;
  logic          free_any;
  logic [2:0]    oh;
  logic          do_upd, do_alloc;

  assign oh = port_onehot(in_port);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = e_val[i] && (e_thr[i] == in_thread) &&
                      (e_wav[i] == in_wave) && (e_slt[i] == in_slot);
    assign done[i]  = e_val[i] && !e_iss[i] && (e_pres[i] == e_need[i]);
    assign freev[i] = !e_val[i];
  end

  opm_pick #(.N(ENTRIES)) i_hit  (.req(match), .any(hit),      .idx(hit_idx));
  opm_pick #(.N(ENTRIES)) i_free (.req(freev), .any(free_any), .idx(free_idx));
  opm_pick #(.N(ENTRIES)) i_rdy  (.req(done),  .any(rdy_any),  .idx(rdy_idx));

  assign full = !free_any;
  assign dup  = hit ? (((e_pres[hit_idx] & oh) != 3'b000) ||
                       ((e_need[hit_idx] & oh) == 3'b000))
                    : ((in_need & oh) == 3'b000);
  assign do_upd   = wr_en && !dup && hit;
  assign do_alloc = wr_en && !dup && !hit && free_any;

  assign out_thread = e_thr[rdy_idx];
  assign out_wave   = e_wav[rdy_idx];
  assign out_slot   = e_slt[rdy_idx];
  assign out_a      = e_opa[rdy_idx];
  assign out_b      = e_opb[rdy_idx];
  assign out_c      = e_opc[rdy_idx];

  // control state
  always_ff @(posedge clk) begin
    if (rst) begin
      e_val <= '0;
      e_iss <= '0;
    end else begin
      if (rel_en) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (e_iss[i]) begin
            e_val[i] <= 1'b0;
            e_iss[i] <= 1'b0;
          end
        end
      end
      if (iss_en) e_iss[rdy_idx] <= 1'b1;
      if (do_alloc) begin
        e_val[free_idx] <= 1'b1;
        e_iss[free_idx] <= 1'b0;
      end
    end
  end

  // tag and presence fields
  always_ff @(posedge clk) begin
    if (do_upd) e_pres[hit_idx] <= e_pres[hit_idx] | oh;
    if (do_alloc) begin
      e_thr[free_idx]  <= in_thread;
      e_wav[free_idx]  <= in_wave;
      e_slt[free_idx]  <= in_slot;
      e_need[free_idx] <= in_need;
      e_pres[free_idx] <= oh;
    end
  end

  // operand storage, one write port per array
  always_ff @(posedge clk) begin
    if (do_upd) begin
      if (oh[0]) e_opa[hit_idx] <= in_value;
      if (oh[1]) e_opb[hit_idx] <= in_value;
      if (oh[2]) e_opc[hit_idx] <= in_value;
    end else if (do_alloc) begin
      e_opa[free_idx] <= oh[0] ? in_value : '0;
      e_opb[free_idx] <= oh[1] ? in_value : '0;
      e_opc[free_idx] <= oh[2] ? in_value : '0;
    end
  end

  AST_UNIQUE_TAG: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match)); // R4
  AST_ALLOC_ROOM: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !hit) |-> free_any); // R7
  AST_ONE_ISSUED: assert property (@(posedge clk) disable iff (rst)
    $countones(e_iss) <= 1); // R9
  AST_ISSUED_KEPT: assert property (@(posedge clk) disable iff (rst)
    ((e_iss != '0) && !rel_en) |=> (e_iss != '0)); // R9
endmodule

// File: rtl/opnd_match.sv
module opnd_match
  import opm_pkg::*;
#(
  parameter int SLOTS   = 8,
  parameter int ENTRIES = 4,
  parameter int TW      = 4,
  parameter int WW      = 8,
  parameter int DW      = 64,
  parameter logic [2*SLOTS-1:0] SLOT_ARITY = 16'hE7B9,
  localparam int SW     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tok_valid,
  output logic          tok_ready,
  input  logic [TW-1:0] tok_thread,
  input  logic [WW-1:0] tok_wave,
  input  logic [SW-1:0] tok_slot,
  input  logic [1:0]    tok_port,
  input  logic [DW-1:0] tok_value,
  output logic          fire_valid,
  input  logic          fire_ready,
  output logic [TW-1:0] fire_thread,
  output logic [WW-1:0] fire_wave,
  output logic [SW-1:0] fire_slot,
  output logic [DW-1:0] fire_a,
  output logic [DW-1:0] fire_b,
  output logic [DW-1:0] fire_c,
  output logic          err_flag
);
  logic [1:0]    cnt;
  logic [2:0]    need;
  logic          single, load_ok, acc, wr_en, take_tbl, take_byp, bad_single;
  logic          hit, full, dup, rdy_any, src_tbl, rel_en;
  logic [TW-1:0] t_thread;
  logic [WW-1:0] t_wave;
  logic [SW-1:0] t_slot;
  logic [DW-1:0] t_a, t_b, t_c;

  assign cnt        = SLOT_ARITY[{tok_slot, 1'b0} +: 2];
  assign need       = need_mask(cnt);
  assign single     = (need == 3'b001);
  assign load_ok    = !fire_valid || fire_ready;
  assign tok_ready  = single ? (load_ok && !rdy_any) : (hit || !full);
  assign acc        = tok_valid && tok_ready;
  assign wr_en      = acc && !single;
  assign take_tbl   = load_ok && rdy_any;
  assign take_byp   = acc && single && (tok_port == PORT_A);
  assign bad_single = acc && single && (tok_port != PORT_A);
  assign rel_en     = fire_valid && fire_ready && src_tbl;

  opm_table #(
    .ENTRIES(ENTRIES), .TW(TW), .WW(WW), .SW(SW), .DW(DW)
  ) i_table (
    .clk(clk), .rst(rst),
    .in_thread(tok_thread), .in_wave(tok_wave), .in_slot(tok_slot),
    .in_port(tok_port), .in_value(tok_value), .in_need(need),
    .wr_en(wr_en), .hit(hit), .full(full), .dup(dup), .rdy_any(rdy_any),
    .iss_en(take_tbl), .rel_en(rel_en),
    .out_thread(t_thread), .out_wave(t_wave), .out_slot(t_slot),
    .out_a(t_a), .out_b(t_b), .out_c(t_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_flag <= 1'b0;
    end else if ((wr_en && dup) || bad_single) begin
      err_flag <= 1'b1;
    end
  end

  // fire register: completed entries win over bypassed single tokens
  always_ff @(posedge clk) begin
    if (rst) begin
      fire_valid  <= 1'b0;
      src_tbl     <= 1'b0;
      fire_thread <= '0;
      fire_wave   <= '0;
      fire_slot   <= '0;
      fire_a      <= '0;
      fire_b      <= '0;
      fire_c      <= '0;
    end else if (take_tbl) begin
      fire_valid  <= 1'b1;
      src_tbl     <= 1'b1;
      fire_thread <= t_thread;
      fire_wave   <= t_wave;
      fire_slot   <= t_slot;
      fire_a      <= t_a;
      fire_b      <= t_b;
      fire_c      <= t_c;
    end else if (take_byp) begin
      fire_valid  <= 1'b1;
      src_tbl     <= 1'b0;
      fire_thread <= tok_thread;
      fire_wave   <= tok_wave;
      fire_slot   <= tok_slot;
      fire_a      <= tok_value;
      fire_b      <= '0;
      fire_c      <= '0;
    end else if (fire_ready) begin
      fire_valid  <= 1'b0;
    end
  end

  AST_FIRE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fire_valid && !fire_ready) |=> (fire_valid && $stable(fire_slot) &&
      $stable(fire_thread) && $stable(fire_wave) && $stable(fire_a) &&
      $stable(fire_b) && $stable(fire_c))); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag); // R8
  AST_SINGLE_NEXT: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && tok_ready && single && tok_port == PORT_A) |=>
      (fire_valid && fire_a == $past(tok_value) && fire_b == '0)); // R5
  AST_NO_FIRE_WAITING: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && tok_ready && single) |-> !rdy_any); // R5
endmodule

// File: tb/test_opnd_match.sv
module test_opnd_match;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 4, WW = 8, SW = 3, DW = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tok_valid = 1'b0;
  logic          tok_ready;
  logic [TW-1:0] tok_thread = '0;
  logic [WW-1:0] tok_wave = '0;
  logic [SW-1:0] tok_slot = '0;
  logic [1:0]    tok_port = '0;
  logic [DW-1:0] tok_value = '0;
  logic          fire_valid;
  logic          fire_ready = 1'b0;
  logic [TW-1:0] fire_thread;
  logic [WW-1:0] fire_wave;
  logic [SW-1:0] fire_slot;
  logic [DW-1:0] fire_a, fire_b, fire_c;
  logic          err_flag;

  int nchk = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  opnd_match i_opnd_match (
    .clk(clk), .rst(rst),
    .tok_valid(tok_valid), .tok_ready(tok_ready),
    .tok_thread(tok_thread), .tok_wave(tok_wave), .tok_slot(tok_slot),
    .tok_port(tok_port), .tok_value(tok_value),
    .fire_valid(fire_valid), .fire_ready(fire_ready),
    .fire_thread(fire_thread), .fire_wave(fire_wave), .fire_slot(fire_slot),
    .fire_a(fire_a), .fire_b(fire_b), .fire_c(fire_c),
    .err_flag(err_flag)
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // drive a token on a falling edge, hold it until taken
  task automatic send(input int slot, input int port, input int thr, input int wav,
                      input logic [63:0] val);
    @(negedge clk);
    tok_slot = SW'(slot); tok_port = 2'(port); tok_thread = TW'(thr);
    tok_wave = WW'(wav); tok_value = val; tok_valid = 1'b1;
    #1;
    while (!tok_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    tok_valid = 1'b0;
  endtask

  // check the packet on the current falling edge, then accept it
  task automatic take(input string rq, input int slot, input int thr, input int wav,
                      input logic [63:0] a, input logic [63:0] b, input logic [63:0] c);
    chk({rq, " fire_valid"}, 64'(fire_valid), 64'd1);
    chk({rq, " slot"}, 64'(fire_slot), 64'(slot));
    chk({rq, " thread"}, 64'(fire_thread), 64'(thr));
    chk({rq, " wave"}, 64'(fire_wave), 64'(wav));
    chk({rq, " a"}, fire_a, a);
    chk({rq, " b"}, fire_b, b);
    chk({rq, " c"}, fire_c, c);
    fire_ready = 1'b1;
    @(negedge clk);
    fire_ready = 1'b0;
  endtask

  // completing multi-operand token: low at first falling edge, high at second (R6)
  task automatic complete(input string rq, input int slot, input int port, input int thr,
                          input int wav, input logic [63:0] val);
    send(slot, port, thr, wav, val);
    chk({rq, " R6 not yet"}, 64'(fire_valid), 64'd0);
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R10 fire_valid", 64'(fire_valid), 64'd0);
    chk("R10 err_flag", 64'(err_flag), 64'd0);
    tok_slot = 3'd1; tok_port = 2'd0;
    #1;
    chk("R10 tok_ready empty", 64'(tok_ready), 64'd1);
  endtask

  task automatic t_single;
    send(0, 0, 2, 7, 64'hDEAD_BEEF_0000_0001);
    take("R5 slot0", 0, 2, 7, 64'hDEAD_BEEF_0000_0001, 0, 0);
    send(5, 0, 1, 3, 64'h55);
    // fire register busy: another single token must wait (R5)
    @(negedge clk);
    tok_slot = 3'd5; tok_port = 2'd0; tok_value = 64'h66; tok_valid = 1'b1;
    #1;
    chk("R5 blocked while busy", 64'(tok_ready), 64'd0);
    tok_valid = 1'b0;
    @(negedge clk);
    take("R5 slot5", 5, 1, 3, 64'h55, 0, 0);
    @(negedge clk);
    chk("R9 drained", 64'(fire_valid), 64'd0);
  endtask

  task automatic t_two;
    send(1, 1, 4, 9, 64'hB1);
    @(negedge clk);
    chk("R1 half set", 64'(fire_valid), 64'd0);
    complete("R1 two-op", 1, 0, 4, 9, 64'hA1);
    take("R2 R3 two-op", 1, 4, 9, 64'hA1, 64'hB1, 0);
  endtask

  task automatic t_three;
    send(2, 2, 6, 1, 64'hC3);
    send(2, 0, 6, 1, 64'hA3);
    @(negedge clk);
    chk("R1 two of three", 64'(fire_valid), 64'd0);
    complete("R3 three-op", 2, 1, 6, 1, 64'hB3);
    take("R3 three-op", 2, 6, 1, 64'hA3, 64'hB3, 64'hC3);
    // slot 4 also needs three (R2)
    send(4, 0, 0, 0, 64'h40);
    send(4, 1, 0, 0, 64'h41);
    @(negedge clk);
    chk("R2 slot4 waits for C", 64'(fire_valid), 64'd0);
    complete("R2 slot4", 4, 2, 0, 0, 64'h42);
    take("R2 slot4", 4, 0, 0, 64'h40, 64'h41, 64'h42);
  endtask

  task automatic t_reentry;
    send(1, 0, 1, 5, 64'h11);
    send(1, 0, 1, 6, 64'h22);
    send(1, 0, 2, 5, 64'h33);
    complete("R4 wave6", 1, 1, 1, 6, 64'h44);
    take("R4 wave6", 1, 1, 6, 64'h22, 64'h44, 0);
    complete("R4 thread2", 1, 1, 2, 5, 64'h55);
    take("R4 thread2", 1, 2, 5, 64'h33, 64'h55, 0);
    complete("R4 wave5", 1, 1, 1, 5, 64'h66);
    take("R4 wave5", 1, 1, 5, 64'h11, 64'h66, 0);
  endtask

  task automatic t_full;
    for (int w = 10; w < 14; w++) send(1, 0, 0, w, 64'(w));
    @(negedge clk);
    tok_slot = 3'd1; tok_port = 2'd0; tok_thread = '0; tok_wave = 8'd14;
    tok_value = 64'h0E; tok_valid = 1'b1;
    #1;
    chk("R7 full blocks new tag", 64'(tok_ready), 64'd0);
    repeat (3) @(negedge clk);
    #1;
    chk("R7 still held", 64'(tok_ready), 64'd0);
    tok_valid = 1'b0;
    complete("R7 match accepted when full", 1, 1, 0, 10, 64'hB0);
    tok_wave = 8'd14; tok_port = 2'd0; tok_value = 64'h0E; tok_valid = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R9 entry kept until accept", 64'(tok_ready), 64'd0);
    chk("R9 held packet wave", 64'(fire_wave), 64'd10);
    chk("R9 held packet b", fire_b, 64'hB0);
    fire_ready = 1'b1;
    @(negedge clk);
    fire_ready = 1'b0;
    #1;
    chk("R9 freed on accept", 64'(tok_ready), 64'd1);
    @(negedge clk);
    tok_valid = 1'b0;
    for (int w = 11; w < 15; w++) begin
      complete("R7 drain", 1, 1, 0, w, 64'h100 + 64'(w));
      take("R7 drain", 1, 0, w, 64'(w), 64'h100 + 64'(w), 0);
    end
  endtask

  task automatic t_dup;
    send(1, 0, 3, 1, 64'hAA);
    chk("R8 clean before", 64'(err_flag), 64'd0);
    send(1, 0, 3, 1, 64'hBB);
    chk("R8 dup sets flag", 64'(err_flag), 64'd1);
    send(1, 2, 3, 1, 64'hCC);
    @(negedge clk);
    chk("R8 dropped, no fire", 64'(fire_valid), 64'd0);
    complete("R8 after dup", 1, 1, 3, 1, 64'hDD);
    take("R8 first value kept", 1, 3, 1, 64'hAA, 64'hDD, 0);
    send(0, 1, 0, 0, 64'hEE);
    chk("R8 single wrong port no fire", 64'(fire_valid), 64'd0);
    chk("R8 sticky", 64'(err_flag), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_single();
    t_two();
    t_three();
    t_reentry();
    t_full();
    t_dup();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nbad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule